// File: doc/BRIEF.md
# Period-Match Timer with Edge Capture

This block is a 16-bit up-counter. Its count clock comes from a prescaler that divides the system clock by a selectable power of two. A compare value sets the period. When the count reaches that value, the counter wraps to zero and raises a period interrupt flag. A separate external input is passed through a two-flop synchronizer and watched for a selectable edge. On that edge, the running count is copied into a capture register and a capture interrupt flag is raised.

The two interrupts work side by side. Software can count period interrupts between two captures, which lets it measure pulses longer than one full timer period. In this mode the waveform output is held low. Software can clear the counter at any time. Each interrupt flag drops when the interrupt controller returns its acknowledge.

Top module: `capture_timer`

## Requirements
- R1: The timer runs only when `enable` is 1 and `mode` equals 2'b01. Otherwise the count and the prescaler are held at zero, and neither flag can be set.
- R2: `presc_sel` values 0 through 7 divide the clock by 1, 2, 4, 8, 32, 128, 512 and 512. The count advances by one on every divided tick. The division phase starts from zero whenever the timer starts or is cleared.
- R3: On a tick where the count equals `compare_val`, the count returns to 0 and `match_irq` is set. Both are visible after that clock edge.
- R4: `sw_clear` high at a clock edge forces the count and the prescaler to zero, and it overrides any tick in that cycle.
- R5: A selected edge on `cap_pin` loads the count into `capture_out` and sets `cap_irq`. Both become visible after the third rising clock edge that follows the pin change.
- R6: `edge_sel` encoding: 2'b00 captures nothing, 2'b01 captures falling edges, 2'b10 captures rising edges, 2'b11 captures both.
- R7: `match_ack` clears `match_irq` and `cap_ack` clears `cap_irq`. A new set in the same cycle wins over the acknowledge.
- R8: `wave_out` stays 0 at all times.
- R9: After reset, the count, the capture value and both flags are zero.
- R10: If a capture edge and a period match fall in the same cycle, the captured value is the count as it was before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Timer run enable |
| mode | input | 2 | Mode field; 2'b01 selects capture operation |
| presc_sel | input | 3 | Prescaler divide select |
| sw_clear | input | 1 | Software clear of count and prescaler |
| compare_val | input | 16 | Period compare value |
| edge_sel | input | 2 | Capture edge polarity select |
| cap_pin | input | 1 | Asynchronous external capture input |
| match_ack | input | 1 | Acknowledge of the period interrupt |
| cap_ack | input | 1 | Acknowledge of the capture interrupt |
| count_out | output | 16 | Current count |
| capture_out | output | 16 | Last captured count |
| match_irq | output | 1 | Period match interrupt flag |
| cap_irq | output | 1 | Capture interrupt flag |
| wave_out | output | 1 | Waveform output, held low in this mode |

## Verification
Count, match and clear results change on the first clock edge after the causing input is sampled. Capture results show up only after the third edge, because the pin first passes two synchronizer flops and then an edge-history flop. The bench drives its inputs on falling edges. It advances a behavioural model on each rising edge and compares every output with that model on the next falling edge, so each result is checked in the cycle it is due and not one earlier. Targeted checks count the same edges explicitly: the capture flag is checked to be still low after the second edge and set after the third.

// File: rtl/ct_pkg.sv
package ct_pkg;

    localparam logic [1:0] MODE_CAPTURE = 2'b01;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_RISE = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    // log2 of the divide ratio for each select code
    function automatic int unsigned div_shift(input logic [2:0] sel);
        case (sel)
            3'd0:    return 0;
            3'd1:    return 1;
            3'd2:    return 2;
            3'd3:    return 3;
            3'd4:    return 5;
            3'd5:    return 7;
            default: return 9;
        endcase
    endfunction

endpackage

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
    parameter int PS_W = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clear,
    input  logic [2:0] sel,
    output logic       tick
);
    typedef struct packed {
        logic [PS_W-1:0] pc;
    } ps_state_t;

    ps_state_t   st_d, st_q;
    logic [PS_W-1:0] mask_d;

    always_comb begin
        st_d   = st_q;
        mask_d = ~({PS_W{1'b1}} << ct_pkg::div_shift(sel));
        tick   = run && !clear && ((st_q.pc & mask_d) == mask_d);
        if (!run || clear) begin
            st_d.pc = '0;
        end else begin
            st_d.pc = st_q.pc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // divide-by-2: a tick is never followed directly by another (R2)
    assert_div2_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel == 3'd1 && $stable(sel)) |=> !tick);

endmodule

// File: rtl/ct_edge_detect.sv
module ct_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic       en,
    input  logic [1:0] sel,
    output logic       evt
);
    localparam int SH_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [SH_W-1:0] sh;
    } ed_state_t;

    ed_state_t st_d, st_q;
    logic      newest, older, rise, fall;

    always_comb begin
        st_d.sh = {st_q.sh[SH_W-2:0], pin};
        newest  = st_q.sh[SH_W-2];
        older   = st_q.sh[SH_W-1];
        rise    = newest && !older;
        fall    = older && !newest;
        evt     = en && ((sel[1] && rise) || (sel[0] && fall));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // an event needs a level change on the synchronized input one cycle earlier (R6)
    assert_evt_from_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> (st_q.sh[SH_W-2] != $past(st_q.sh[SH_W-2])));

endmodule

// File: rtl/ct_core.sv
module ct_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             sw_clear,
    input  logic             tick,
    input  logic             cap_evt,
    input  logic [CNT_W-1:0] cmp,
    input  logic             match_ack,
    input  logic             cap_ack,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] capv,
    output logic             mflag,
    output logic             cflag
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] capv;
        logic             mflag;
        logic             cflag;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        hit;

    always_comb begin
        st_d = st_q;
        hit  = tick && (st_q.cnt == cmp);

        if (!run || sw_clear) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = hit ? '0 : st_q.cnt + 1'b1;
        end

        if (hit)            st_d.mflag = 1'b1;
        else if (match_ack) st_d.mflag = 1'b0;

        if (cap_evt) begin
            st_d.capv  = st_q.cnt;
            st_d.cflag = 1'b1;
        end else if (cap_ack) begin
            st_d.cflag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt   = st_q.cnt;
    assign capv  = st_q.capv;
    assign mflag = st_q.mflag;
    assign cflag = st_q.cflag;

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

    assert_no_step_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !sw_clear && !tick) |=> $stable(cnt));

    assert_match_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == cmp) |=> (cnt == '0 && mflag));

    assert_soft_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clear |=> (cnt == '0));

    assert_capture_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (capv == $past(cnt) && cflag));

    assert_match_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (match_ack && !(tick && cnt == cmp)) |=> !mflag);

    assert_cap_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_ack && !cap_evt) |=> !cflag);

endmodule

// File: rtl/capture_timer.sv
module capture_timer #(
    parameter int CNT_W       = 16,
    parameter int PS_W        = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       mode,
    input  logic [2:0]       presc_sel,
    input  logic             sw_clear,
    input  logic [CNT_W-1:0] compare_val,
    input  logic [1:0]       edge_sel,
    input  logic             cap_pin,
    input  logic             match_ack,
    input  logic             cap_ack,
    output logic [CNT_W-1:0] count_out,
    output logic [CNT_W-1:0] capture_out,
    output logic             match_irq,
    output logic             cap_irq,
    output logic             wave_out
);
    logic run;
    logic tick;
    logic cap_evt;

    assign run      = enable && (mode == ct_pkg::MODE_CAPTURE);
    assign wave_out = 1'b0;

    ct_prescaler #(.PS_W(PS_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clear (sw_clear),
        .sel   (presc_sel),
        .tick  (tick)
    );

    ct_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (cap_pin),
        .en    (run),
        .sel   (edge_sel),
        .evt   (cap_evt)
    );

    ct_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .sw_clear  (sw_clear),
        .tick      (tick),
        .cap_evt   (cap_evt),
        .cmp       (compare_val),
        .match_ack (match_ack),
        .cap_ack   (cap_ack),
        .cnt       (count_out),
        .capv      (capture_out),
        .mflag     (match_irq),
        .cflag     (cap_irq)
    );

    // no interrupt can rise while the timer is stopped (R1)
    assert_stopped_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!$rose(match_irq) && !$rose(cap_irq)));

endmodule

// File: tb/capture_timer_tb.sv
module capture_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  mode = 2'b01;
    logic [2:0]  presc_sel = 3'd0;
    logic        sw_clear = 1'b0;
    logic [15:0] compare_val = 16'hFFFF;
    logic [1:0]  edge_sel = 2'b00;
    logic        cap_pin = 1'b0;
    logic        match_ack = 1'b0;
    logic        cap_ack = 1'b0;
    logic [15:0] count_out, capture_out;
    logic        match_irq, cap_irq, wave_out;

    always #10 clk = ~clk;

    capture_timer u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
        .presc_sel(presc_sel), .sw_clear(sw_clear), .compare_val(compare_val),
        .edge_sel(edge_sel), .cap_pin(cap_pin), .match_ack(match_ack),
        .cap_ack(cap_ack), .count_out(count_out), .capture_out(capture_out),
        .match_irq(match_irq), .cap_irq(cap_irq), .wave_out(wave_out)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_cnt = 0, m_pc = 0, m_cap = 0;
    bit m_mf = 0, m_cf = 0, m_collide = 0;
    bit pin_q[$] = '{1'b0, 1'b0, 1'b0};   // [0] newest sample
    int collisions = 0;

    function automatic int divisor(input logic [2:0] s);
        case (s)
            3'd0: return 1;   3'd1: return 2;   3'd2: return 4;
            3'd3: return 8;   3'd4: return 32;  3'd5: return 128;
            default: return 512;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_pc = 0; m_cap = 0; m_mf = 0; m_cf = 0; m_collide = 0;
            pin_q = '{1'b0, 1'b0, 1'b0};
        end else begin
            bit run, rise, fall, evt, tck, hit;
            int dv;
            run  = enable && (mode == 2'b01);
            dv   = divisor(presc_sel);
            rise = pin_q[1] && !pin_q[2];
            fall = !pin_q[1] && pin_q[2];
            evt  = run && ((edge_sel[1] && rise) || (edge_sel[0] && fall));
            tck  = run && !sw_clear && ((m_pc % dv) == dv - 1);
            hit  = tck && (m_cnt == int'(compare_val));
            if (evt) begin
                m_cap = m_cnt; m_cf = 1; m_collide = hit;
                if (hit) collisions++;
            end else if (cap_ack) m_cf = 0;
            if (hit) m_mf = 1;
            else if (match_ack) m_mf = 0;
            if (!run || sw_clear) begin
                m_cnt = 0; m_pc = 0;
            end else begin
                m_pc = (m_pc + 1) % 512;
                if (tck) m_cnt = hit ? 0 : (m_cnt + 1) % 65536;
            end
            void'(pin_q.pop_back());
            pin_q.push_front(cap_pin);
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            check("R2 R3 count", int'(count_out), m_cnt);
            check(m_collide ? "R10 capture" : "R5 capture", int'(capture_out), m_cap);
            check("R3 R7 match_irq", int'(match_irq), int'(m_mf));
            check("R5 R7 cap_irq", int'(cap_irq), int'(m_cf));
            check("R8 wave_out", int'(wave_out), 0);
        end
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stop_restart();
        enable = 1'b0; step(1); enable = 1'b1;
    endtask

    initial begin
        int c0;
        step(2);
        // R9: reset state
        check("R9 count", int'(count_out), 0);
        check("R9 capture", int'(capture_out), 0);
        check("R9 match_irq", int'(match_irq), 0);
        check("R9 cap_irq", int'(cap_irq), 0);
        rst_n = 1'b1;
        step(2);
        check("R8 wave idle", int'(wave_out), 0);

        // R1: wrong mode keeps the timer at zero
        mode = 2'b10; enable = 1'b1; step(20);
        check("R1 wrong mode", int'(count_out), 0);
        mode = 2'b01; enable = 1'b0; step(20);
        check("R1 disabled", int'(count_out), 0);

        // R3: period match with compare 9 at divide 1
        compare_val = 16'd9; enable = 1'b1; step(10);
        check("R3 wrap", int'(count_out), 0);
        check("R3 flag", int'(match_irq), 1);
        match_ack = 1'b1; step(1); match_ack = 1'b0;
        check("R7 match ack", int'(match_irq), 0);
        step(30);

        // R2: each divide ratio, four ticks
        compare_val = 16'hFFFF;
        for (int s = 0; s < 8; s++) begin
            presc_sel = 3'(s); stop_restart();
            step(4 * divisor(3'(s)));
            check("R2 divide", int'(count_out), 4);
        end

        // R4: software clear mid-count
        presc_sel = 3'd0; stop_restart(); step(25);
        sw_clear = 1'b1; step(1); sw_clear = 1'b0;
        check("R4 clear", int'(count_out), 0);
        step(5);

        // R5: rising capture latency
        edge_sel = 2'b10; c0 = int'(count_out);
        cap_pin = 1'b1; step(2);
        check("R5 not yet", int'(cap_irq), 0);
        step(1);
        check("R5 flag", int'(cap_irq), 1);
        check("R5 value", int'(capture_out), c0 + 2);
        cap_ack = 1'b1; step(1); cap_ack = 1'b0;
        check("R7 cap ack", int'(cap_irq), 0);

        // R6: falling edge ignored in rising mode, taken in falling mode
        cap_pin = 1'b0; step(6);
        check("R6 rise only", int'(cap_irq), 0);
        edge_sel = 2'b00; cap_pin = 1'b1; step(6); cap_pin = 1'b0; step(6);
        check("R6 off", int'(cap_irq), 0);
        edge_sel = 2'b01; cap_pin = 1'b1; step(6); cap_pin = 1'b0; step(6);
        check("R6 falling", int'(cap_irq), 1);
        cap_ack = 1'b1; step(1); cap_ack = 1'b0;
        edge_sel = 2'b11;
        for (int k = 0; k < 4; k++) begin
            cap_pin = ~cap_pin; step(5);
            check("R6 both", int'(cap_irq), 1);
            cap_ack = 1'b1; step(1); cap_ack = 1'b0;
        end

        // R10: sweep edge phases against a 10-cycle period
        compare_val = 16'd9; edge_sel = 2'b10; stop_restart();
        for (int k = 0; k < 12; k++) begin
            cap_pin = 1'b1; step(5); cap_pin = 1'b0; step(6);
        end
        check("R10 collision seen", int'(collisions > 0), 1);

        // R7: set wins over simultaneous ack (checked every cycle by model)
        match_ack = 1'b1; step(40); match_ack = 1'b0;
        presc_sel = 3'd2; compare_val = 16'd3; step(200);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule